// File: doc/BRIEF.md
# MDIO Management Master with Clock-Range Divider

This block runs single read and write transactions to an external PHY over the two-wire management interface. A host presents a PHY address, a register address, an operation, 16-bit write data and a 4-bit clock-range code, then pulses a start strobe. The block latches all of them, derives the management clock from the system clock, and shifts out a 64-bit frame on the data line. It drives the line for the whole frame on writes. On reads it releases the line from the turnaround onward. The 16 returned bits are collected on rising management-clock edges.

The management-clock divisor is not a free count. It comes from a fixed, non-uniform table indexed by the clock-range code. The six standard codes fit system clocks from about 20 to 300 MHz and aim at the usual 1.0 to 2.5 MHz management clock. The eight fast codes give small even divisors for PHYs that accept a faster clock. While a transaction runs the busy output is high. When it drops, the read result is valid and stays unchanged until the next start.

Top module: `mdio_master`

## Requirements
- R1: A frame is 64 bits, sent MSB first, one bit per MDC period. The fields are:
  - 32 ones;
  - start pattern 01;
  - opcode 10 for a read (`op_i`=0) or 01 for a write (`op_i`=1);
  - the 5-bit PHY address;
  - the 5-bit register address;
  - a 2-bit turnaround;
  - 16 data bits.

  Each driven bit is stable at the rising MDC edge.
- R2: Clock-range codes 0, 1, 2, 3, 4 and 5 select system-clock divisors of 42, 62, 16, 26, 102 and 124 respectively.
- R3: Codes 8 to 15 select divisors 4, 6, 8, 10, 12, 14, 16 and 18 respectively.
- R4: Reserved codes 6 and 7 select divisor 42.
- R5: With divisor D, each MDC period has D/2 system clocks low followed by D/2 high. The first period starts low on the cycle after the start is accepted, and MDC stays low whenever the block is idle.
- R6: `busy_o` rises on the edge that accepts a start and stays high for exactly 64×D system clocks. It falls on the edge that ends the last MDC period.
- R7: In a write, `mdio_oe_o` is high for all 64 bits, the turnaround is driven as 1 then 0, and the data is the write data.
- R8: In a read:
  - `mdio_oe_o` is high for the first 46 bits and low for the turnaround and data bits;
  - the 16 data bits are sampled from `mdio_i` at the rising MDC edges of bits 48 to 63, MSB first;
  - `rdata_o` keeps its value until a later read shifts in new bits, so a write leaves it unchanged.
- R9: A start strobe while `busy_o` is high is ignored. The running frame, its length and its inputs are unaffected.
- R10: After reset `busy_o`, `mdc_o` and `mdio_oe_o` are 0, `mdio_o` is 1 and `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only when idle |
| op_i | input | 1 | 0 = read, 1 = write |
| phy_addr_i | input | 5 | PHY address |
| reg_addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| clk_sel_i | input | 4 | Clock-range code selecting the MDC divisor |
| mdio_i | input | 1 | Sampled management data line |
| busy_o | output | 1 | Transaction in progress |
| rdata_o | output | 16 | Read result, valid while idle after a read |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven value |
| mdio_oe_o | output | 1 | Drive enable for the management data line |

## Verification
Every result is due at a fixed distance from the edge that accepts a start.
- `busy_o` is seen high at the first falling system-clock edge after that edge.
- The first MDC rise shows D/2+1 samples into the transaction, and the second shows D samples later.
- `busy_o` stays high for exactly 64×D samples.
- `rdata_o` is compared on the first sample after `busy_o` falls.

The bench samples only on falling system-clock edges, counts them from the start, and compares each value at the count the requirement gives. The PHY model changes `mdio_i` one sample after each observed MDC fall, so the value is settled half an MDC period before the edge that samples it.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } mdio_op_e;

  localparam int unsigned SEL_W = 4;
  localparam int unsigned DIV_W = 8;

  // Codes with bit 3 set: 4 + 2*n. Codes 6/7 fall back to 42.
  function automatic logic [DIV_W-1:0] sel_to_div(input logic [SEL_W-1:0] sel);
    logic [DIV_W-1:0] d;
    if (sel[3]) begin
      d = DIV_W'(4) + DIV_W'({sel[2:0], 1'b0});
    end else begin
      case (sel[2:0])
        3'd1:    d = DIV_W'(62);
        3'd2:    d = DIV_W'(16);
        3'd3:    d = DIV_W'(26);
        3'd4:    d = DIV_W'(102);
        3'd5:    d = DIV_W'(124);
        default: d = DIV_W'(42);
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/mdio_div_sel.sv
module mdio_div_sel
  import mdio_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  output logic [DIV_W-1:0] div_o
);

  always_comb div_o = sel_to_div(sel_i);

  always_comb begin
    AST_DIV_EVEN: assert (div_o[0] == 1'b0 && div_o >= DIV_W'(4)); // R2
  end

endmodule

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] half_m1;
  logic [DIV_W-1:0] full_m1;

  assign half_m1 = (div_i >> 1) - ONE;
  assign full_m1 = div_i - ONE;
  assign rise_o  = run_i && (cnt_q == half_m1);
  assign fall_o  = run_i && (cnt_q == full_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else if (load_i || !run_i) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else begin
      cnt_q <= fall_o ? '0 : cnt_q + ONE;
      if (rise_o)      mdc_o <= 1'b1;
      else if (fall_o) mdc_o <= 1'b0;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q < div_i); // R2

  AST_MDC_RISE_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_o) |-> cnt_q == (div_i >> 1)); // R5

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int unsigned PRE_W  = 32,
  parameter int unsigned PHY_AW = 5,
  parameter int unsigned REG_AW = 5,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              busy_i,
  input  logic              op_i,
  input  logic [PHY_AW-1:0] phy_i,
  input  logic [REG_AW-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              last_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int unsigned HDR_W   = 6 + PHY_AW + REG_AW;
  localparam int unsigned FRAME_W = PRE_W + HDR_W + DATA_W;
  localparam int unsigned TA_POS  = PRE_W + HDR_W - 2;
  localparam int unsigned DAT_POS = PRE_W + HDR_W;
  localparam int unsigned BIT_W   = $clog2(FRAME_W);

  mdio_op_e           op_q;
  logic [FRAME_W-1:0] shift_q;
  logic [BIT_W-1:0]   bit_q;
  logic [FRAME_W-1:0] frame_d;

  always_comb begin
    if (mdio_op_e'(op_i) == OP_WRITE)
      frame_d = {{PRE_W{1'b1}}, 2'b01, 2'b01, phy_i, reg_i, 2'b10, wdata_i};
    else
      frame_d = {{PRE_W{1'b1}}, 2'b01, 2'b10, phy_i, reg_i, 2'b11, {DATA_W{1'b1}}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_READ;
      shift_q <= '1;
      bit_q   <= '0;
      rdata_o <= '0;
    end else if (load_i) begin
      op_q    <= mdio_op_e'(op_i);
      shift_q <= frame_d;
      bit_q   <= '0;
    end else if (busy_i) begin
      if (fall_i) begin
        shift_q <= {shift_q[FRAME_W-2:0], 1'b1};
        bit_q   <= bit_q + BIT_W'(1);
      end
      if (rise_i && op_q == OP_READ && bit_q >= BIT_W'(DAT_POS))
        rdata_o <= {rdata_o[DATA_W-2:0], mdio_i};
    end
  end

  assign mdio_o    = busy_i ? shift_q[FRAME_W-1] : 1'b1;
  assign mdio_oe_o = busy_i && (op_q == OP_WRITE || bit_q < BIT_W'(TA_POS));
  assign last_o    = (bit_q == BIT_W'(FRAME_W - 1));

  AST_WRITE_TA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && op_q == OP_WRITE && bit_q == BIT_W'(TA_POS) |-> mdio_o); // R7

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> $stable(rdata_o)); // R8

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned PHY_AW = 5,
  parameter int unsigned REG_AW = 5,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              op_i,
  input  logic [PHY_AW-1:0] phy_addr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [SEL_W-1:0]  clk_sel_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o
);

  logic             accept;
  logic             rise, fall, last;
  logic [DIV_W-1:0] div_sel, div_q;

  assign accept = start_i && !busy_o;

  mdio_div_sel i_div_sel (
    .sel_i (clk_sel_i),
    .div_o (div_sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      div_q  <= DIV_W'(42);
    end else if (accept) begin
      busy_o <= 1'b1;
      div_q  <= div_sel;
    end else if (fall && last) begin
      busy_o <= 1'b0;
    end
  end

  mdio_clk_gen #(.DIV_W(DIV_W)) i_clk_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .run_i  (busy_o),
    .div_i  (div_q),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame #(
    .PRE_W  (32),
    .PHY_AW (PHY_AW),
    .REG_AW (REG_AW),
    .DATA_W (DATA_W)
  ) i_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .busy_i    (busy_o),
    .op_i      (op_i),
    .phy_i     (phy_addr_i),
    .reg_i     (reg_addr_i),
    .wdata_i   (wdata_i),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .last_o    (last),
    .rdata_o   (rdata_o)
  );

  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(div_q)); // R9

  AST_MDC_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mdc_o); // R5

  AST_OE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mdio_oe_o); // R10

endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  // {sel[54:51], op[50], phy[49:45], reg[44:40], wdata[39:24], phy_rd[23:8], div[7:0]}
  localparam logic [54:0] VEC [NVEC] = '{
    {4'd0,  1'b0, 5'h01, 5'h02, 16'h0000, 16'hA5C3, 8'd42},
    {4'd1,  1'b1, 5'h1F, 5'h00, 16'h8001, 16'h0000, 8'd62},
    {4'd2,  1'b0, 5'h10, 5'h1F, 16'h0000, 16'h0001, 8'd16},
    {4'd3,  1'b1, 5'h0A, 5'h15, 16'h5A5A, 16'h0000, 8'd26},
    {4'd4,  1'b0, 5'h05, 5'h0A, 16'h0000, 16'hFFFE, 8'd102},
    {4'd5,  1'b1, 5'h00, 5'h01, 16'hFFFF, 16'h0000, 8'd124},
    {4'd6,  1'b0, 5'h03, 5'h04, 16'h0000, 16'h1234, 8'd42},
    {4'd7,  1'b1, 5'h1E, 5'h11, 16'h0F0F, 16'h0000, 8'd42},
    {4'd8,  1'b0, 5'h11, 5'h03, 16'h0000, 16'h8000, 8'd4},
    {4'd15, 1'b1, 5'h07, 5'h1C, 16'hC001, 16'h0000, 8'd18},
    {4'd10, 1'b0, 5'h12, 5'h09, 16'h0000, 16'h7FFF, 8'd8},
    {4'd9,  1'b1, 5'h01, 5'h01, 16'h1111, 16'h0000, 8'd6},
    {4'd14, 1'b0, 5'h02, 5'h02, 16'h0000, 16'h2222, 8'd16}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op = 1'b0;
  logic [4:0]  phy = '0;
  logic [4:0]  rga = '0;
  logic [15:0] wdata = '0;
  logic [3:0]  sel = '0;
  logic        mdio_in = 1'b1;
  logic        busy;
  logic [15:0] rdata;
  logic        mdc, mdio_out, mdio_oe;

  int n_run = 0;
  int n_fail = 0;
  logic [15:0] last_rd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master i_mdio_master (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .op_i       (op),
    .phy_addr_i (phy),
    .reg_addr_i (rga),
    .wdata_i    (wdata),
    .clk_sel_i  (sel),
    .mdio_i     (mdio_in),
    .busy_o     (busy),
    .rdata_o    (rdata),
    .mdc_o      (mdc),
    .mdio_o     (mdio_out),
    .mdio_oe_o  (mdio_oe)
  );

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic txn(input logic [3:0] s, input logic o, input logic [4:0] pa,
                     input logic [4:0] ra, input logic [15:0] wd, input logic [15:0] rd,
                     input int d, input string dtag, input logic inject);
    logic [63:0] exp_frame, exp_oe, mask, got, oe_got;
    int cyc, rises, falls, r1, r2;
    logic prev;
    exp_frame = {32'hFFFF_FFFF, 2'b01, (o ? 2'b01 : 2'b10), pa, ra,
                 (o ? 2'b10 : 2'b11), (o ? wd : 16'hFFFF)};
    exp_oe = o ? '1 : {{46{1'b1}}, 18'b0};
    mask   = exp_oe;
    got = '0; oe_got = '0; cyc = 0; rises = 0; falls = 0; r1 = 0; r2 = 0;
    @(negedge clk);
    sel = s; op = o; phy = pa; rga = ra; wdata = wd; mdio_in = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    prev = 1'b0;
    while (busy) begin
      cyc++;
      if (inject && cyc == 100) begin
        start = 1'b1; op = ~o; phy = ~pa; sel = 4'd5;
      end
      if (inject && cyc == 101) start = 1'b0;
      if (mdc && !prev) begin
        if (rises < 64) begin
          got[63-rises] = mdio_out;
          oe_got[63-rises] = mdio_oe;
        end
        rises++;
        if (rises == 1) r1 = cyc;
        if (rises == 2) r2 = cyc;
      end
      if (!mdc && prev) begin
        falls++;
        if (!o && falls >= 48 && falls < 64) mdio_in = rd[63-falls];
      end
      prev = mdc;
      @(negedge clk);
    end
    mdio_in = 1'b1;
    check(r1 == d/2 + 1, dtag, "first MDC rise cycle", 64'(r1), 64'(d/2 + 1));
    check(r2 == d/2 + 1 + d, inject ? "R9" : "R5", "MDC period", 64'(r2 - r1), 64'(d));
    check(cyc == 64*d, inject ? "R9" : "R6", "busy length", 64'(cyc), 64'(64*d));
    check(rises == 64, "R1", "MDC rise count", 64'(rises), 64'd64);
    check((got & mask) == (exp_frame & mask), inject ? "R9" : "R1", "frame bits",
          got & mask, exp_frame & mask);
    check(oe_got == exp_oe, o ? "R7" : "R8", "drive enable", oe_got, exp_oe);
    if (!o) last_rd = rd;
    check(rdata == last_rd, "R8", "read data", 64'(rdata), 64'(last_rd));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R6 watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state, sampled while reset is held and after release
    check(!busy && !mdc && !mdio_oe && mdio_out && rdata == '0, "R10", "in reset",
          {busy, mdc, mdio_oe, mdio_out, rdata}, {4'b0001, 16'h0});
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !mdc && !mdio_oe && mdio_out, "R10", "idle after reset",
          {busy, mdc, mdio_oe, mdio_out}, 4'b0001);

    for (int i = 0; i < NVEC; i++) begin
      logic [3:0] s;
      string t;
      s = VEC[i][54:51];
      t = (s < 4'd6) ? "R2" : (s < 4'd8) ? "R4" : "R3";
      txn(s, VEC[i][50], VEC[i][49:45], VEC[i][44:40], VEC[i][39:24],
          VEC[i][23:8], int'(VEC[i][7:0]), t, 1'b0);
      check(!mdc && !mdio_oe, "R5", "idle after frame", {mdc, mdio_oe}, 2'b00);
    end

    // R9 start while busy: write at divisor 4, retriggered mid-frame
    txn(4'd8, 1'b1, 5'h15, 5'h0A, 16'hBEEF, 16'h0, 4, "R9", 1'b1);
    // R9 read with restart attempt; read data must be the PHY's, not disturbed
    txn(4'd11, 1'b0, 5'h0C, 5'h13, 16'h0, 16'h6C39, 10, "R9", 1'b1);
    // R8 write following read keeps read result
    txn(4'd12, 1'b1, 5'h1B, 5'h06, 16'h0001, 16'h0, 12, "R3", 1'b0);
    repeat (5) @(negedge clk);
    check(rdata == 16'h6C39, "R8", "read data held while idle", 64'(rdata), 64'h6C39);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule